// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Phase Alignment

This block derives the local multiframe clock of a subclass-1 serial converter-link receiver from a free-running core clock that carries four octets per cycle. A multiframe holds K frames of F octets each. The block counts core-clock words through each multiframe and marks every boundary with a one-cycle tick. It brings the external SYSREF reference into the core domain through a synchronizer and uses its rising edges to set the multiframe phase. An edge that arrives out of phase with the running count is reported. The SYSREF period is expected to be an integer multiple of the multiframe length, for example one SYSREF every four multiframes.

Software-facing logic sets the frame size, the multiframe size, a release delay in frames and a mode bit. With the mode bit clear, only the first SYSREF edge after reset sets the phase, and later edges are only compared against it. With the mode bit set, every edge moves the phase. A release strobe for the downstream elastic buffer fires a programmable number of frames after each boundary. Configurations that cannot be mapped onto whole core-clock words are refused.

Top module: `lmfc_gen`

## Requirements
- R1: With a valid configuration, `mf_tick` is high for exactly one cycle in every K*F/4 cycles, where F = `cfg_frame_octets` and K = `cfg_frames_per_mf`.
- R2: `sysref` passes through two synchronizing flops and a rising-edge detector. A rise first sampled at clock edge n realigns the count, so `mf_tick` is high in the cycle after edge n+2. A level held high yields one event only.
- R3: The first SYSREF edge after reset always realigns the multiframe count and never raises `sysref_phase_err`.
- R4: With `cfg_realign_always` = 0, later SYSREF edges leave the multiframe phase unchanged. One that is out of phase raises `sysref_phase_err` for one cycle, in the cycle after edge n+2.
- R5: With `cfg_realign_always` = 1, every SYSREF edge realigns the count. An out-of-phase edge still raises `sysref_phase_err` in the same cycle as the new boundary tick.
- R6: A SYSREF edge whose detection falls in the last cycle of a multiframe is in phase. It raises no error and causes no shift of the boundary.
- R7: `buf_release` is high floor(RBD*F/4) cycles after each boundary, where RBD = `cfg_release_delay`. With RBD = K it coincides with the boundary, and with RBD = 0 it does too.
- R8: `buf_release` stays low until the first SYSREF alignment after reset.
- R9: `cfg_invalid` is high when F = 0, K = 0, F > 16, K > 32, RBD > K, or K*F is not a multiple of 4. While it is high, `mf_tick`, `buf_release` and `sysref_phase_err` stay low and the alignment state is cleared.
- R10: During reset with a valid configuration, `sysref_phase_err`, `buf_release` and `cfg_invalid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, four octets per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref | input | 1 | SYSREF reference, asynchronous to `clk` |
| cfg_frame_octets | input | 5 | F, octets per frame (1..16) |
| cfg_frames_per_mf | input | 6 | K, frames per multiframe (1..32) |
| cfg_release_delay | input | 6 | RBD, release delay in frames (0..K) |
| cfg_realign_always | input | 1 | 1: every SYSREF edge realigns; 0: only the first one does |
| mf_tick | output | 1 | One-cycle multiframe boundary pulse |
| buf_release | output | 1 | Elastic-buffer release strobe |
| sysref_phase_err | output | 1 | One-cycle flag for an out-of-phase SYSREF edge |
| cfg_invalid | output | 1 | Configuration cannot be used |

## Verification
Inputs change on falling edges. A SYSREF rise driven before clock edge n produces its realigned tick, or its error flag, in the third sampled cycle after the rise, because three registers lie on the path: two synchronizer stages and the counter or error flop. The checks wait exactly that many falling edges before they sample. After alignment, the bench tracks the expected phase by counting cycles from the realigned tick. It then checks the tick and release strobe in every cycle of two multiframes for each table configuration. `cfg_invalid` is combinational from the configuration, so it is checked in the same cycle the configuration is applied.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
  // default limits for the multiframe configuration
  localparam int unsigned LMFC_F_MAX_DEF = 16;
  localparam int unsigned LMFC_K_MAX_DEF = 32;
  // octets carried per core-clock cycle
  localparam int unsigned LMFC_OCT_PER_CLK_DEF = 4;
  // synchronizer depth for the reference input
  localparam int unsigned LMFC_SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/lmfc_cfg_decode.sv
module lmfc_cfg_decode #(
  parameter int unsigned F_MAX       = 16,
  parameter int unsigned K_MAX       = 32,
  parameter int unsigned OCT_PER_CLK = 4,
  parameter int unsigned FW          = 5,
  parameter int unsigned KW          = 6,
  parameter int unsigned CW          = 8
) (
  input  logic [FW-1:0] cfg_f,
  input  logic [KW-1:0] cfg_k,
  input  logic [KW-1:0] cfg_rbd,
  output logic [CW-1:0] last,
  output logic [CW-1:0] rel_pos,
  output logic          cfg_ok
);
  localparam int unsigned PW = FW + KW;

  logic [PW-1:0] mf_oct;
  logic [PW-1:0] rel_oct;
  logic [CW-1:0] mf_len;
  logic [CW-1:0] rel_clk;

  always_comb begin
    mf_oct  = PW'(cfg_k) * PW'(cfg_f);
    rel_oct = PW'(cfg_rbd) * PW'(cfg_f);
    mf_len  = CW'(mf_oct / PW'(OCT_PER_CLK));
    rel_clk = CW'(rel_oct / PW'(OCT_PER_CLK));
    cfg_ok  = (cfg_f != '0) && (cfg_k != '0) &&
              (cfg_f <= FW'(F_MAX)) && (cfg_k <= KW'(K_MAX)) &&
              (cfg_rbd <= cfg_k) &&
              ((mf_oct % PW'(OCT_PER_CLK)) == '0);
    last    = mf_len - 1'b1;
    // a delay of a full multiframe lands on the next boundary
    rel_pos = (rel_clk >= mf_len) ? '0 : rel_clk;
  end
endmodule

// File: rtl/lmfc_sysref_sync.sv
module lmfc_sysref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], sysref};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2: a detected rise lasts a single cycle
  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lmfc_mf_counter.sv
module lmfc_mf_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ok,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] rel_pos,
  input  logic          realign_all,
  input  logic          sysref_rise,
  output logic          mf_tick,
  output logic          buf_release,
  output logic          phase_err
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          aligned_q, aligned_d;
  logic          err_q, err_d;
  logic          at_end;
  logic          take;

  always_comb begin
    at_end    = (cnt_q >= last);
    take      = sysref_rise && (!aligned_q || realign_all);
    cnt_d     = at_end ? '0 : cnt_q + 1'b1;
    aligned_d = aligned_q;
    err_d     = 1'b0;
    if (!cfg_ok) begin
      cnt_d     = '0;
      aligned_d = 1'b0;
    end else begin
      // in phase only when detected in the final word of the multiframe
      err_d = sysref_rise && aligned_q && !at_end;
      if (take) begin
        cnt_d     = '0;
        aligned_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      aligned_q <= aligned_d;
      err_q     <= err_d;
    end
  end

  assign mf_tick     = cfg_ok && (cnt_q == '0);
  assign buf_release = cfg_ok && aligned_q && (cnt_q == rel_pos);
  assign phase_err   = err_q;

  // R1: the count stays inside the multiframe while the length is steady
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && $past(cfg_ok) && $stable(last)) |-> (cnt_q <= last));
  // R3: the first reference edge sets the phase to zero
  p_first_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && sysref_rise && !aligned_q) |=> (cnt_q == '0) && aligned_q);
  // R3: the first reference edge never reports an error
  p_first_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_rise && !aligned_q) |=> !phase_err);
  // R5: every edge realigns in continuous mode
  p_resync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && sysref_rise && realign_all) |=> (cnt_q == '0));
  // R4: the error flag is a single-cycle pulse
  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> !phase_err);
  // R9: a refused configuration clears the alignment state
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> (cnt_q == '0) && !aligned_q && !phase_err);
endmodule

// File: rtl/lmfc_gen.sv
module lmfc_gen
  import lmfc_pkg::*;
#(
  parameter int unsigned F_MAX       = LMFC_F_MAX_DEF,
  parameter int unsigned K_MAX       = LMFC_K_MAX_DEF,
  parameter int unsigned OCT_PER_CLK = LMFC_OCT_PER_CLK_DEF,
  parameter int unsigned SYNC_STAGES = LMFC_SYNC_STAGES_DEF,
  localparam int unsigned FW = $clog2(F_MAX + 1),
  localparam int unsigned KW = $clog2(K_MAX + 1),
  localparam int unsigned CW = $clog2(F_MAX * K_MAX / OCT_PER_CLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sysref,
  input  logic [FW-1:0] cfg_frame_octets,
  input  logic [KW-1:0] cfg_frames_per_mf,
  input  logic [KW-1:0] cfg_release_delay,
  input  logic          cfg_realign_always,
  output logic          mf_tick,
  output logic          buf_release,
  output logic          sysref_phase_err,
  output logic          cfg_invalid
);
  logic [CW-1:0] last;
  logic [CW-1:0] rel_pos;
  logic          cfg_ok;
  logic          sysref_rise;

  lmfc_cfg_decode #(
    .F_MAX(F_MAX), .K_MAX(K_MAX), .OCT_PER_CLK(OCT_PER_CLK),
    .FW(FW), .KW(KW), .CW(CW)
  ) u_dec (
    .cfg_f   (cfg_frame_octets),
    .cfg_k   (cfg_frames_per_mf),
    .cfg_rbd (cfg_release_delay),
    .last    (last),
    .rel_pos (rel_pos),
    .cfg_ok  (cfg_ok)
  );

  lmfc_sysref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sysref (sysref),
    .rise   (sysref_rise)
  );

  lmfc_mf_counter #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ok      (cfg_ok),
    .last        (last),
    .rel_pos     (rel_pos),
    .realign_all (cfg_realign_always),
    .sysref_rise (sysref_rise),
    .mf_tick     (mf_tick),
    .buf_release (buf_release),
    .phase_err   (sysref_phase_err)
  );

  assign cfg_invalid = !cfg_ok;
endmodule

// File: tb/lmfc_gen_tb_top.sv
module lmfc_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] f;
    logic [7:0] k;
    logic [7:0] rbd;
    logic [7:0] len;
    logic [7:0] rel;
    logic       bad;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'd32, 8'd0,  8'd16, 8'd0, 1'b0},
    '{8'd2, 8'd32, 8'd5,  8'd16, 8'd2, 1'b0},
    '{8'd2, 8'd32, 8'd32, 8'd16, 8'd0, 1'b0},
    '{8'd8, 8'd4,  8'd0,  8'd8,  8'd0, 1'b0},
    '{8'd8, 8'd4,  8'd3,  8'd8,  8'd6, 1'b0},
    '{8'd8, 8'd4,  8'd4,  8'd8,  8'd0, 1'b0},
    '{8'd1, 8'd4,  8'd1,  8'd1,  8'd0, 1'b0},
    '{8'd4, 8'd3,  8'd2,  8'd3,  8'd2, 1'b0},
    '{8'd3, 8'd5,  8'd0,  8'd0,  8'd0, 1'b1},
    '{8'd2, 8'd4,  8'd5,  8'd0,  8'd0, 1'b1},
    '{8'd0, 8'd4,  8'd0,  8'd0,  8'd0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysref = 1'b0;
  logic [4:0] cfg_f = 5'd8;
  logic [5:0] cfg_k = 6'd4;
  logic [5:0] cfg_rbd = 6'd0;
  logic       cfg_all = 1'b0;
  logic       mf_tick, buf_release, sysref_phase_err, cfg_invalid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmfc_gen dut_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .sysref             (sysref),
    .cfg_frame_octets   (cfg_f),
    .cfg_frames_per_mf  (cfg_k),
    .cfg_release_delay  (cfg_rbd),
    .cfg_realign_always (cfg_all),
    .mf_tick            (mf_tick),
    .buf_release        (buf_release),
    .sysref_phase_err   (sysref_phase_err),
    .cfg_invalid        (cfg_invalid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int f, input int k, input int rbd, input bit all);
    @(negedge clk);
    rst_n   = 1'b0;
    sysref  = 1'b0;
    cfg_f   = 5'(f);
    cfg_k   = 6'(k);
    cfg_rbd = 6'(rbd);
    cfg_all = all;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  // raise the reference for one cycle; returns at the third sampled cycle after the rise
  task automatic ref_pulse();
    sysref = 1'b1;
    @(negedge clk);
    sysref = 1'b0;
    wait_n(2);
  endtask

  initial begin
    int errs;
    int rels;
    int ticks;

    // R10: state during reset
    do_reset(8, 4, 0, 1'b0);
    rst_n = 1'b0;
    wait_n(2);
    chk("R10 err in reset", int'(sysref_phase_err), 0);
    chk("R10 release in reset", int'(buf_release), 0);
    chk("R10 cfg_invalid in reset", int'(cfg_invalid), 0);

    // table walk: R1 period, R7 release position, R9 refused configs, R3 first alignment
    for (int v = 0; v < NV; v++) begin
      do_reset(int'(VECS[v].f), int'(VECS[v].k), int'(VECS[v].rbd), 1'b0);
      chk($sformatf("R9 cfg_invalid vec%0d", v), int'(cfg_invalid), int'(VECS[v].bad));
      if (!VECS[v].bad) begin
        ref_pulse();
        chk($sformatf("R3 first err vec%0d", v), int'(sysref_phase_err), 0);
        for (int c = 0; c < 2 * int'(VECS[v].len) + 1; c++) begin
          chk($sformatf("R1 tick vec%0d cyc%0d", v, c), int'(mf_tick),
              int'((c % int'(VECS[v].len)) == 0));
          chk($sformatf("R7 release vec%0d cyc%0d", v, c), int'(buf_release),
              int'((c % int'(VECS[v].len)) == int'(VECS[v].rel)));
          @(negedge clk);
        end
      end else begin
        ticks = 0;
        rels = 0;
        sysref = 1'b1;
        for (int c = 0; c < 12; c++) begin
          @(negedge clk);
          if (c == 1) sysref = 1'b0;
          ticks += int'(mf_tick);
          rels += int'(buf_release) + int'(sysref_phase_err);
        end
        chk($sformatf("R9 no ticks vec%0d", v), ticks, 0);
        chk($sformatf("R9 no release or err vec%0d", v), rels, 0);
      end
    end

    // R4: later edges only checked when realign mode is off (F=8 K=4, 8 cycles)
    do_reset(8, 4, 0, 1'b0);
    ref_pulse();
    chk("R3 aligned tick", int'(mf_tick), 1);
    wait_n(1);                 // phase 1
    ref_pulse();               // phase 4
    chk("R4 err flagged", int'(sysref_phase_err), 1);
    chk("R4 no tick on misaligned", int'(mf_tick), 0);
    wait_n(1);                 // phase 5
    chk("R4 err one cycle", int'(sysref_phase_err), 0);
    wait_n(3);                 // phase 0
    chk("R4 phase kept", int'(mf_tick), 1);

    // R6: in-phase edge is silent
    wait_n(5);                 // phase 5
    ref_pulse();               // phase 0
    chk("R6 tick kept", int'(mf_tick), 1);
    chk("R6 no err", int'(sysref_phase_err), 0);
    chk("R7 release with RBD 0", int'(buf_release), 1);

    // R5: continuous realign
    cfg_all = 1'b1;
    wait_n(1);                 // phase 1
    ref_pulse();               // new phase 0
    chk("R5 realigned tick", int'(mf_tick), 1);
    chk("R5 err reported", int'(sysref_phase_err), 1);
    wait_n(4);
    chk("R5 old boundary gone", int'(mf_tick), 0);
    wait_n(4);
    chk("R5 new boundary", int'(mf_tick), 1);

    // R2: held level counts once
    wait_n(1);
    sysref = 1'b1;
    errs = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (c == 20) sysref = 1'b0;
      errs += int'(sysref_phase_err);
    end
    chk("R2 held level single event", errs, 1);

    // R8: no release before alignment
    do_reset(8, 4, 3, 1'b0);
    rels = 0;
    ticks = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      rels += int'(buf_release);
      ticks += int'(mf_tick);
    end
    chk("R8 release before alignment", rels, 0);
    chk("R1 ticks before alignment", int'(ticks > 0), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule